// File: doc/BRIEF.md
# Pipelined Quadratic Root Counter

This block takes the three signed coefficients of a quadratic, a, b and c. It produces the discriminant b·b − 4·a·c and a two-bit count of how many real roots the quadratic has. The count follows from the sign of the discriminant. The datapath is a fixed register schedule, not a single combinational expression. Each coefficient set carries a valid bit that travels with it, and each result comes out with its own valid strobe.

The parameter `SHARED` picks one of two forms. With `SHARED = 0`, two multipliers of seven stages each form b·b and a·c side by side, so the block accepts a new coefficient set on every cycle. Three more register stages follow: the first shifts the a·c product left by two, the second subtracts, and the third classifies the result and registers it. With `SHARED = 1`, one four-stage multiplier is used twice for each set. It forms b·b in the cycle the set is accepted and a·c in the next cycle. A shift stage and a combined subtract-and-classify stage follow. In this form the block accepts at most one set every two cycles, and `in_ready` tells the source when the next set may be offered.

All arithmetic is two's complement. The discriminant output is 2W+3 bits wide for W-bit coefficients, so it is exact for every input.

Top module: `disc_root_pipe`

## Requirements
- R1: For every accepted (a, b, c), `out_delta` equals b·b − 4·a·c exactly, as a signed two's-complement value 2W+3 bits wide.
- R2: `out_roots` is 2'd2 when the discriminant is positive, 2'd1 when it is zero and 2'd0 when it is negative. The code 2'd3 never appears with `out_valid` high.
- R3: With `SHARED = 0`, `in_ready` stays high and a set may be accepted on every cycle. The result appears on the outputs at the 10th rising edge, counting the accepting edge as the first.
- R4: With `SHARED = 1`, the result appears at the 7th rising edge, counting the accepting edge as the first. Two results are never flagged valid on back-to-back cycles.
- R5: With `SHARED = 1`, `in_ready` is low in the cycle after an acceptance and high again in the cycle after that. A set offered while `in_ready` is low is ignored.
- R6: A set is accepted when `in_valid` and `in_ready` are both high at a rising edge. Each accepted set gives exactly one valid result, and results come out in acceptance order. Cycles with `in_valid` low give no result.
- R7: While `out_valid` is low, `out_delta` and `out_roots` keep their last values.
- R8: While `rst` is high at a rising edge, the pipeline is emptied and `out_valid`, `out_delta` and `out_roots` are cleared to zero. With `SHARED = 1`, `in_ready` is also set high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A coefficient set is offered |
| in_a | input | W | Coefficient a, signed |
| in_b | input | W | Coefficient b, signed |
| in_c | input | W | Coefficient c, signed |
| in_ready | output | 1 | The block can accept a set at the next edge |
| out_valid | output | 1 | A result is present this cycle |
| out_delta | output | 2W+3 | Discriminant b·b − 4·a·c, signed |
| out_roots | output | 2 | Number of real roots: 0, 1 or 2 |

## Verification
The assertions check, on every cycle, the rules that can be stated at the ports: the root code is legal and agrees with the sign of the discriminant, results appear exactly at the form's latency after an acceptance and only then, the outputs hold while no result is flagged, and in the shared form `in_ready` alternates and results are spaced apart. Only the bench's scenarios can show that the discriminant value itself is right. To do that, the bench drives every 4-bit triple through both forms, once back to back and once with idle gaps in the full-throughput form. It also drives extra sets while `in_ready` is low and checks that they are ignored. It compares each result against a value computed arithmetically in the bench.

// File: rtl/disc_root_pkg.sv
package disc_root_pkg;

  // Root-count code; the discriminant sign selects one of these.
  typedef enum logic [1:0] {
    ROOTS_NONE = 2'd0,
    ROOTS_ONE  = 2'd1,
    ROOTS_TWO  = 2'd2
  } roots_e;

endpackage

// File: rtl/disc_mult_pipe.sv
// Signed multiplier followed by a register chain of STAGES deep,
// with a side tag that travels in lockstep with the product.
module disc_mult_pipe #(
  parameter int IW     = 16,
  parameter int STAGES = 4,
  parameter int TW     = 1,
  localparam int PW    = 2 * IW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [IW-1:0] op_x,
  input  logic signed [IW-1:0] op_y,
  input  logic [TW-1:0]        tag_in,
  output logic signed [PW-1:0] prod,
  output logic [TW-1:0]        tag_out
);

  logic signed [PW-1:0] pr_q [STAGES];
  logic [TW-1:0]        tg_q [STAGES];

  // Data stages carry no reset so they map onto plain DSP/pipeline registers.
  always_ff @(posedge clk) begin
    pr_q[0] <= PW'(op_x) * PW'(op_y);
    for (int i = 1; i < STAGES; i++) begin
      pr_q[i] <= pr_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) begin
        tg_q[i] <= '0;
      end
    end else begin
      tg_q[0] <= tag_in;
      for (int i = 1; i < STAGES; i++) begin
        tg_q[i] <= tg_q[i-1];
      end
    end
  end

  assign prod    = pr_q[STAGES-1];
  assign tag_out = tg_q[STAGES-1];

endmodule

// File: rtl/disc_classify.sv
// Final stage: registers the discriminant and its root count.
module disc_classify #(
  parameter int DW = 35
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 diff_valid,
  input  logic signed [DW-1:0] diff,
  output logic                 res_valid,
  output logic signed [DW-1:0] res_delta,
  output logic [1:0]           res_roots
);
  import disc_root_pkg::*;

  roots_e roots_d;

  always_comb begin
    if (diff[DW-1])      roots_d = ROOTS_NONE;
    else if (diff == '0) roots_d = ROOTS_ONE;
    else                 roots_d = ROOTS_TWO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_delta <= '0;
      res_roots <= 2'd0;
    end else begin
      res_valid <= diff_valid;
      if (diff_valid) begin
        res_delta <= diff;
        res_roots <= roots_d;
      end
    end
  end

endmodule

// File: rtl/disc_root_pipe.sv
// Discriminant and real-root counter, full-throughput or shared-multiplier form.
module disc_root_pipe #(
  parameter int W               = 16,
  parameter bit SHARED          = 1'b0,
  parameter int FULL_MUL_STAGES = 7,
  parameter int HALF_MUL_STAGES = 4,
  localparam int DW             = 2 * W + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_a,
  input  logic signed [W-1:0]  in_b,
  input  logic signed [W-1:0]  in_c,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_delta,
  output logic [1:0]           out_roots
);

  localparam int PW = 2 * W;

  logic                 accept;
  logic                 diff_valid;
  logic signed [DW-1:0] diff;

  generate
    if (!SHARED) begin : g_full
      logic signed [PW-1:0] p_bb, p_ac;
      logic                 t_bb, t_ac;
      logic signed [DW-1:0] sq_q, fac4_q, d_q;
      logic                 v_sh_q, v_sub_q;

      assign in_ready = 1'b1;
      assign accept   = in_valid;

      disc_mult_pipe #(.IW(W), .STAGES(FULL_MUL_STAGES), .TW(1)) u_mul_bb (
        .clk(clk), .rst(rst), .op_x(in_b), .op_y(in_b),
        .tag_in(accept), .prod(p_bb), .tag_out(t_bb)
      );

      disc_mult_pipe #(.IW(W), .STAGES(FULL_MUL_STAGES), .TW(1)) u_mul_ac (
        .clk(clk), .rst(rst), .op_x(in_a), .op_y(in_c),
        .tag_in(accept), .prod(p_ac), .tag_out(t_ac)
      );

      // Shift stage, then subtract stage.
      always_ff @(posedge clk) begin
        sq_q   <= DW'(p_bb);
        fac4_q <= DW'(p_ac) <<< 2;
        d_q    <= sq_q - fac4_q;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          v_sh_q  <= 1'b0;
          v_sub_q <= 1'b0;
        end else begin
          v_sh_q  <= t_bb & t_ac;
          v_sub_q <= v_sh_q;
        end
      end

      assign diff       = d_q;
      assign diff_valid = v_sub_q;
    end else begin : g_half
      logic                 phase_q;
      logic signed [W-1:0]  hold_a_q, hold_c_q;
      logic signed [W-1:0]  mx, my;
      logic signed [PW-1:0] p_m;
      logic [1:0]           t_m;   // [0] first pass (b*b), [1] second pass (a*c)
      logic signed [DW-1:0] sq_q, fac4_q;
      logic                 v_sh_q;

      assign in_ready = ~phase_q;
      assign accept   = in_valid & ~phase_q;

      always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= accept;
      end

      always_ff @(posedge clk) begin
        if (accept) begin
          hold_a_q <= in_a;
          hold_c_q <= in_c;
        end
      end

      assign mx = phase_q ? hold_a_q : in_b;
      assign my = phase_q ? hold_c_q : in_b;

      disc_mult_pipe #(.IW(W), .STAGES(HALF_MUL_STAGES), .TW(2)) u_mul (
        .clk(clk), .rst(rst), .op_x(mx), .op_y(my),
        .tag_in({phase_q, accept}), .prod(p_m), .tag_out(t_m)
      );

      always_ff @(posedge clk) begin
        if (t_m[0]) sq_q   <= DW'(p_m);
        if (t_m[1]) fac4_q <= DW'(p_m) <<< 2;
      end

      always_ff @(posedge clk) begin
        if (rst) v_sh_q <= 1'b0;
        else     v_sh_q <= t_m[1];
      end

      // Subtraction shares the final stage with classification.
      assign diff       = sq_q - fac4_q;
      assign diff_valid = v_sh_q;
    end
  endgenerate

  disc_classify #(.DW(DW)) u_cls (
    .clk(clk), .rst(rst),
    .diff_valid(diff_valid), .diff(diff),
    .res_valid(out_valid), .res_delta(out_delta), .res_roots(out_roots)
  );

endmodule

// File: rtl/disc_root_chk.sv
module disc_root_chk #(
  parameter int W               = 16,
  parameter bit SHARED          = 1'b0,
  parameter int FULL_MUL_STAGES = 7,
  parameter int HALF_MUL_STAGES = 4,
  localparam int DW             = 2 * W + 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_delta,
  input logic [1:0]           out_roots
);

  localparam int LAT = SHARED ? (HALF_MUL_STAGES + 3) : (FULL_MUL_STAGES + 3);

  logic acc;
  assign acc = in_valid & in_ready & ~rst;

  a_r2_roots_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_roots != 2'd3));

  a_r2_roots_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (((out_roots == 2'd2) == (out_delta > 0)) &&
                   ((out_roots == 2'd1) == (out_delta == 0))));

  // R3 / R4 latency, R6 one result per acceptance
  a_r6_result_follows: assert property (@(posedge clk) disable iff (rst)
    $past(acc, LAT) |-> out_valid);

  a_r6_result_has_source: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(acc, LAT));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_delta) && $stable(out_roots)));

  generate
    if (SHARED) begin : g_sh
      a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

      a_r5_ready_returns: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

      a_r4_spaced: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    end
  endgenerate

endmodule

bind disc_root_pipe disc_root_chk #(
  .W(W), .SHARED(SHARED),
  .FULL_MUL_STAGES(FULL_MUL_STAGES), .HALF_MUL_STAGES(HALF_MUL_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_delta(out_delta), .out_roots(out_roots)
);

// File: tb/disc_root_pipe_test.sv
module disc_root_pipe_test;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int DW         = 2 * W + 3;
  localparam int LAT_FULL   = 10;
  localparam int LAT_HALF   = 7;
  localparam int N          = 1 << (3 * W);
  localparam int MASK       = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Full-throughput instance
  logic                 v_f = 1'b0;
  logic signed [W-1:0]  a_f = '0, b_f = '0, c_f = '0;
  logic                 rdy_f, ov_f;
  logic signed [DW-1:0] d_f;
  logic [1:0]           r_f;

  // Shared-multiplier instance
  logic                 v_h = 1'b0;
  logic signed [W-1:0]  a_h = '0, b_h = '0, c_h = '0;
  logic                 rdy_h, ov_h;
  logic signed [DW-1:0] d_h;
  logic [1:0]           r_h;

  disc_root_pipe #(.W(W), .SHARED(1'b0)) uut (
    .clk(clk), .rst(rst), .in_valid(v_f), .in_a(a_f), .in_b(b_f), .in_c(c_f),
    .in_ready(rdy_f), .out_valid(ov_f), .out_delta(d_f), .out_roots(r_f)
  );

  disc_root_pipe #(.W(W), .SHARED(1'b1)) uut_shared (
    .clk(clk), .rst(rst), .in_valid(v_h), .in_a(a_h), .in_b(b_h), .in_c(c_h),
    .in_ready(rdy_h), .out_valid(ov_h), .out_delta(d_h), .out_roots(r_h)
  );

  // Scoreboards
  int exp_d_f [2*N];
  int exp_t_f [2*N];
  int wr_f = 0, rd_f = 0;
  int exp_d_h [N];
  int exp_t_h [N];
  int wr_h = 0, rd_h = 0;
  int last_d_f = 0, last_r_f = 0, last_d_h = 0, last_r_h = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int disc(input int a, input int b, input int c);
    return b * b - 4 * a * c;
  endfunction

  function automatic int roots_of(input int d);
    return (d > 0) ? 2 : ((d == 0) ? 1 : 0);
  endfunction

  function automatic logic signed [W-1:0] fld(input int idx, input int k);
    return W'((idx >> (k * W)) & MASK);
  endfunction

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rdy_f == 1'b1, "R3", "full-form ready", rdy_f, 1);
      if (ov_f) begin
        if (rd_f >= wr_f) begin
          chk(1'b0, "R6", "full-form result with nothing accepted", 1, 0);
        end else begin
          chk(int'(d_f) == exp_d_f[rd_f], "R1", "full-form delta", int'(d_f), exp_d_f[rd_f]);
          chk(int'(r_f) == roots_of(exp_d_f[rd_f]), "R2", "full-form roots",
              r_f, roots_of(exp_d_f[rd_f]));
          chk(cyc == exp_t_f[rd_f] + LAT_FULL - 1, "R3", "full-form latency edge",
              cyc, exp_t_f[rd_f] + LAT_FULL - 1);
          rd_f++;
        end
        last_d_f = int'(d_f);
        last_r_f = int'(r_f);
      end else begin
        chk(int'(d_f) == last_d_f && int'(r_f) == last_r_f, "R7", "full-form hold delta",
            int'(d_f), last_d_f);
      end
      if (ov_h) begin
        if (rd_h >= wr_h) begin
          chk(1'b0, "R5", "shared-form result for an ignored set", 1, 0);
        end else begin
          chk(int'(d_h) == exp_d_h[rd_h], "R1", "shared-form delta", int'(d_h), exp_d_h[rd_h]);
          chk(int'(r_h) == roots_of(exp_d_h[rd_h]), "R2", "shared-form roots",
              r_h, roots_of(exp_d_h[rd_h]));
          chk(cyc == exp_t_h[rd_h] + LAT_HALF - 1, "R4", "shared-form latency edge",
              cyc, exp_t_h[rd_h] + LAT_HALF - 1);
          rd_h++;
        end
        last_d_h = int'(d_h);
        last_r_h = int'(r_h);
      end else begin
        chk(int'(d_h) == last_d_h && int'(r_h) == last_r_h, "R7", "shared-form hold delta",
            int'(d_h), last_d_h);
      end
    end
  end

  task automatic drive_full();
    // Pass 1: back to back
    for (int idx = 0; idx < N; idx++) begin
      @(negedge clk);
      a_f = fld(idx, 0); b_f = fld(idx, 1); c_f = fld(idx, 2); v_f = 1'b1;
      exp_d_f[wr_f] = disc(int'(a_f), int'(b_f), int'(c_f));
      exp_t_f[wr_f] = cyc + 1;
      wr_f++;
    end
    // Pass 2: idle gaps carrying garbage (R6: no result for them)
    for (int idx = 0; idx < N; idx++) begin
      if (idx % 3 == 1) begin
        @(negedge clk);
        v_f = 1'b0;
        a_f = fld(idx + 5, 0); b_f = fld(idx + 7, 1); c_f = fld(idx, 2);
      end
      @(negedge clk);
      a_f = fld(idx, 2); b_f = fld(idx, 0); c_f = fld(idx, 1); v_f = 1'b1;
      exp_d_f[wr_f] = disc(int'(a_f), int'(b_f), int'(c_f));
      exp_t_f[wr_f] = cyc + 1;
      wr_f++;
    end
    @(negedge clk);
    v_f = 1'b0;
  endtask

  task automatic drive_shared();
    int idx = 0;
    while (idx < N) begin
      @(negedge clk);
      if (rdy_h) begin
        a_h = fld(idx, 0); b_h = fld(idx, 1); c_h = fld(idx, 2); v_h = 1'b1;
        exp_d_h[wr_h] = disc(int'(a_h), int'(b_h), int'(c_h));
        exp_t_h[wr_h] = cyc + 1;
        wr_h++;
        idx++;
      end else begin
        // R5: offered while not ready, must be ignored
        a_h = fld(idx + 3, 1); b_h = fld(idx + 9, 2); c_h = fld(idx, 0); v_h = 1'b1;
      end
    end
    @(negedge clk);
    v_h = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(ov_f == 1'b0 && ov_h == 1'b0, "R8", "out_valid in reset", ov_f | ov_h, 0);
    chk(d_f == '0 && r_f == 2'd0, "R8", "full-form outputs in reset", int'(d_f), 0);
    chk(d_h == '0 && r_h == 2'd0, "R8", "shared-form outputs in reset", int'(d_h), 0);
    chk(rdy_h == 1'b1, "R8", "shared-form ready in reset", rdy_h, 1);
    rst = 1'b0;
    fork
      drive_full();
      drive_shared();
    join
    repeat (LAT_FULL + 4) @(negedge clk);
    chk(rd_f == wr_f && wr_f == 2 * N, "R6", "full-form results delivered", rd_f, 2 * N);
    chk(rd_h == wr_h && wr_h == N, "R6", "shared-form results delivered", rd_h, N);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule